// File: doc/BRIEF.md
# Cyclic-Schedule Row-to-Column Soft-Value Interconnect

This block links N row decoders to N column decoders in a full-parallel product-code turbo decoder. Because rows and columns walk the N×N matrix on a cyclic schedule, no matrix memory is needed between half-iterations. Row decoder i starts at position i and steps its index up by one (mod N) on each clock. Column decoder j starts at position j and steps its index down by one (mod N). At schedule index t, row i therefore emits the element in column (i+t) mod N. Column j needs the element of row (j−t) mod N. The routing is a circular rotation of the input ports by t. The rotation is built from ceil(log2 N) stages of two-way selectors; stage k rotates by 2^k mod N.

A two-state scheduler (`ST_IDLE`, `ST_RUN`) produces the rotation amount:
- **Frame start** (`ST_IDLE`→`ST_RUN`): a `frame_start` pulse marks index 0.
- **Step** (`ST_RUN`→`ST_RUN`): the index advances by one per clock.
- **Restart** (`ST_RUN`→`ST_RUN`): `frame_start` during a frame forces index 0 again.
- **Wrap** (`ST_RUN`→`ST_IDLE`): after index N−1 with no new start, the scheduler goes idle.

Two identical rotation paths carry the channel values and the current soft inputs under the same permutation. Both paths feed a one-cycle output register with a valid flag. Each port carries 25 bits: five 5-bit LLRs of one GF(32) symbol.

Top module: `rowcol_rotnet`

## Requirements
- R1: While and after reset, before any `frame_start`, `out_valid` is 0 and every output port is 0.
- R2: The cycle with `frame_start` high is index 0. One clock later, `out_valid` is 1 and every column port j holds row port j's input from that cycle (identity).
- R3: For a symbol presented at index t, column port j delivers row port (j−t) mod N. The result appears on the clock after the inputs, with `out_valid` high. Port k occupies bits [k*25 +: 25] of each flat vector.
- R4: The index rises by one per clock. After index N−1 with no `frame_start`, the scheduler goes idle, and `out_valid` is 0 for the results of the following cycle.
- R5: A `frame_start` in the cycle right after index N−1 begins a new matrix at index 0, with no gap in `out_valid`.
- R6: A `frame_start` during a running frame restarts the schedule at index 0 in that same cycle.
- R7: The R network (`r_in`→`r_out`) and the R_iter network (`ri_in`→`ri_out`) apply the same permutation, and each carries only its own data.
- R8: Over one N-cycle matrix, every (row, column) element arrives exactly once, at its own column port.
- R9: While idle, input data is ignored: `out_valid` stays 0 and the output ports hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Marks index 0 of a matrix |
| r_in | input | N*W | Channel soft values from the N row decoders |
| ri_in | input | N*W | Current soft inputs from the N row decoders |
| r_out | output | N*W | Channel soft values to the N column decoders |
| ri_out | output | N*W | Current soft inputs to the N column decoders |
| out_valid | output | 1 | Output ports carry routed data |

## Verification
The assertions assume `frame_start` is held low during reset. They also assume the row decoders present matrix data only in cycles the scheduler treats as valid, meaning a start cycle or an `ST_RUN` cycle. The bench keeps to this: it drives the start strobe only after reset and places tagged matrix elements only in scheduled cycles. In idle cycles it drives random data, which the design must ignore. Every tagged element carries its row, column, frame and network. From these tags the bench checks that each element lands once, at its owning column, and never on the other network.

// File: rtl/rcnet_pkg.sv
package rcnet_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sched_st_e;

    // Source port feeding port j after a rotation by amt, modulo n.
    function automatic int unsigned rot_src(int unsigned j, int unsigned amt, int unsigned n);
        return (j + n - (amt % n)) % n;
    endfunction
endpackage

// File: rtl/rcnet_sched.sv
module rcnet_sched
    import rcnet_pkg::*;
#(
    parameter int N  = 31,
    parameter int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic          cur_valid,
    output logic [SW-1:0] cur_shift
);
    localparam logic [SW-1:0] LAST = SW'(N - 1);
    localparam logic [SW-1:0] ONE  = SW'(1);

    sched_st_e     state, nxt_state;
    logic [SW-1:0] cnt, nxt_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        cur_valid = 1'b0;
        cur_shift = '0;
        unique case (state)
            ST_IDLE: begin
                if (frame_start) begin
                    cur_valid = 1'b1;
                    nxt_state = ST_RUN;
                    nxt_cnt   = ONE;
                end
            end
            ST_RUN: begin
                cur_valid = 1'b1;
                if (frame_start) begin
                    nxt_cnt = ONE;
                end else begin
                    cur_shift = cnt;
                    if (cnt == LAST) begin
                        nxt_state = ST_IDLE;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt + ONE;
                    end
                end
            end
            default: ;
        endcase
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt <= LAST));

    // R4
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_valid) && ($past(cur_shift) != LAST) && !frame_start)
        |-> (cur_valid && (cur_shift == $past(cur_shift) + ONE)));

    // R4
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_valid) && ($past(cur_shift) == LAST) && !frame_start)
        |-> !cur_valid);
endmodule

// File: rtl/rcnet_rotor.sv
module rcnet_rotor
    import rcnet_pkg::*;
#(
    parameter int N  = 31,
    parameter int W  = 25,
    parameter int SW = $clog2(N)
) (
    input  logic [SW-1:0]  shift,
    input  logic [N*W-1:0] din,
    output logic [N*W-1:0] dout
);
    logic [SW:0][N-1:0][W-1:0] stg;

    assign stg[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        for (genvar j = 0; j < N; j++) begin : g_port
            localparam int unsigned SRC = rot_src(j, (1 << k), N);
            assign stg[k+1][j] = shift[k] ? stg[k][SRC] : stg[k][j];
        end
    end

    assign dout = stg[SW];
endmodule

// File: rtl/rowcol_rotnet.sv
module rowcol_rotnet
    import rcnet_pkg::*;
#(
    parameter int N = 31,
    parameter int W = 25
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic [N*W-1:0] r_in,
    input  logic [N*W-1:0] ri_in,
    output logic [N*W-1:0] r_out,
    output logic [N*W-1:0] ri_out,
    output logic           out_valid
);
    localparam int SW   = $clog2(N);
    localparam int NETS = 2;

    logic          cur_valid;
    logic [SW-1:0] cur_shift;

    logic [NETS-1:0][N*W-1:0] net_in, net_rot, net_q;
    logic                     valid_q;

    rcnet_sched #(.N(N), .SW(SW)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .cur_valid  (cur_valid),
        .cur_shift  (cur_shift)
    );

    assign net_in[0] = r_in;
    assign net_in[1] = ri_in;

    for (genvar n = 0; n < NETS; n++) begin : g_net
        rcnet_rotor #(.N(N), .W(W), .SW(SW)) u_rotor (
            .shift(cur_shift),
            .din  (net_in[n]),
            .dout (net_rot[n])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                net_q[n] <= '0;
            end else if (cur_valid) begin
                net_q[n] <= net_rot[n];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= cur_valid;
        end
    end

    assign r_out     = net_q[0];
    assign ri_out    = net_q[1];
    assign out_valid = valid_q;

    // Checking aids: row port that column 0 should draw from this cycle.
    logic [SW-1:0] col0_idx;
    logic [W-1:0]  r_col0_src, ri_col0_src;
    always_comb begin
        col0_idx    = (cur_shift == '0) ? '0 : SW'(N - int'(cur_shift));
        r_col0_src  = r_in[int'(col0_idx)*W +: W];
        ri_col0_src = ri_in[int'(col0_idx)*W +: W];
    end

    // R3
    col0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cur_valid) |-> (r_out[W-1:0] == $past(r_col0_src)));

    // R7
    col0_iter_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cur_valid) |-> (ri_out[W-1:0] == $past(ri_col0_src)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cur_valid) |-> ($stable(r_out) && $stable(ri_out) && !out_valid));
endmodule

// File: tb/rowcol_rotnet_bench.sv
`timescale 1ns/1ps
module rowcol_rotnet_bench;
    localparam int N  = 31;
    localparam int W  = 25;
    localparam int TW = N * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [TW-1:0] r_in = '0;
    logic [TW-1:0] ri_in = '0;
    logic [TW-1:0] r_out, ri_out;
    logic          out_valid;

    always #2.5 clk = ~clk;

    rowcol_rotnet #(.N(N), .W(W)) u_rowcol_rotnet (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .r_in(r_in), .ri_in(ri_in), .r_out(r_out), .ri_out(ri_out),
        .out_valid(out_valid)
    );

    int         errs = 0;
    int         checks = 0;
    logic [W-1:0] exp_r [N];
    logic [W-1:0] exp_ri[N];
    bit         exp_v = 1'b0;
    int         midx = -1;
    int         hits [N][N];
    bit         cov_en = 1'b0;
    int         cov_frame = 1;
    string      prev_tag = "R1";

    // Symbol tag: {net, salt[8:0], frame[4:0], row[4:0], col[4:0]}
    function automatic logic [W-1:0] mk(int net, int row, int col, int frm, int salt);
        logic [W-1:0] s;
        s = {net[0], salt[8:0], frm[4:0], row[4:0], col[4:0]};
        return s;
    endfunction

    task automatic compare(string tg);
        bit bad_r, bad_ri;
        checks++;
        if (out_valid !== exp_v) begin
            errs++;
            $display("FAIL %s out_valid got %0b exp %0b", tg, out_valid, exp_v);
        end
        bad_r = 1'b0;
        bad_ri = 1'b0;
        for (int j = 0; j < N; j++) begin
            if (r_out[j*W +: W] !== exp_r[j]) begin
                if (!bad_r) $display("FAIL %s r_out port %0d got %h exp %h", tg, j, r_out[j*W +: W], exp_r[j]);
                bad_r = 1'b1;
            end
            if (ri_out[j*W +: W] !== exp_ri[j]) begin
                if (!bad_ri) $display("FAIL R7 [%s] ri_out port %0d got %h exp %h", tg, j, ri_out[j*W +: W], exp_ri[j]);
                bad_ri = 1'b1;
            end
        end
        checks += 2;
        if (bad_r) errs++;
        if (bad_ri) errs++;
        if (cov_en && out_valid === 1'b1) begin
            for (int j = 0; j < N; j++) begin
                logic [W-1:0] g;
                g = r_out[j*W +: W];
                if (int'(g[14:10]) == cov_frame && int'(g[4:0]) == j && int'(g[9:5]) < N)
                    hits[int'(g[9:5])][j]++;
            end
        end
    endtask

    task automatic cyc(bit st, int frm, string tg);
        int t;
        @(negedge clk);
        compare(prev_tag);
        prev_tag = tg;
        frame_start = st;
        t = st ? 0 : midx;
        for (int i = 0; i < N; i++) begin
            if (t >= 0) begin
                r_in[i*W +: W]  = mk(0, i, (i + t) % N, frm, i + 7);
                ri_in[i*W +: W] = mk(1, i, (i + t) % N, frm, 3 * i + 1);
            end else begin
                r_in[i*W +: W]  = W'($urandom);
                ri_in[i*W +: W] = W'($urandom);
            end
        end
        exp_v = (t >= 0);
        if (t >= 0) begin
            for (int j = 0; j < N; j++) begin
                int src;
                src = (j - t + N) % N;
                exp_r[j]  = r_in[src*W +: W];
                exp_ri[j] = ri_in[src*W +: W];
            end
        end
        midx = (t >= 0 && t < N - 1) ? t + 1 : -1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int j = 0; j < N; j++) begin
            exp_r[j] = '0;
            exp_ri[j] = '0;
        end
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
                hits[a][b] = 0;

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            compare("R1");
        end
        rst_n = 1'b1;

        // R9: idle with random input data
        repeat (3) cyc(1'b0, 0, "R9");

        // R2, R3, R8: one full matrix
        cov_en = 1'b1;
        cyc(1'b1, 1, "R2");
        for (int t = 1; t < N; t++) cyc(1'b0, 1, "R3");

        // R5: back-to-back matrix
        cyc(1'b1, 2, "R5");
        cov_en = 1'b0;
        begin
            bit ok;
            ok = 1'b1;
            for (int a = 0; a < N; a++)
                for (int b = 0; b < N; b++)
                    if (hits[a][b] != 1) begin
                        if (ok) $display("FAIL R8 element row %0d col %0d hits %0d exp 1", a, b, hits[a][b]);
                        ok = 1'b0;
                    end
            checks++;
            if (!ok) errs++;
        end
        for (int t = 1; t < N; t++) cyc(1'b0, 2, "R5");

        // R4 then R9: wrap to idle, outputs hold
        cyc(1'b0, 0, "R4");
        repeat (3) cyc(1'b0, 0, "R9");

        // R6: restart during a frame
        cyc(1'b1, 3, "R6");
        for (int t = 1; t < 10; t++) cyc(1'b0, 3, "R3");
        cyc(1'b1, 4, "R6");
        for (int t = 1; t < N; t++) cyc(1'b0, 4, "R7");
        cyc(1'b0, 0, "R4");
        cyc(1'b0, 0, "R9");
        @(negedge clk);
        compare(prev_tag);

        summary();
        $finish;
    end
endmodule